// File: doc/BRIEF.md
# Biphase Mark Timecode Bit Decoder

This block turns a biphase-mark timecode line into a serial stream of decoded bits. The line is presented as two flags, polarity and exact-zero, that are valid on a sample tick. The block finds each transition, counts the ticks up to the next one, and calls the interval long or short against a single tick threshold. A long interval is a 0 and two short intervals in a row are a 1. The one threshold covers the 24, 25 and 30 frame-per-second cell lengths: a full cell is at least about 41.7 ticks of 10 µs, and a half cell is at most 26 ticks.

The decoder stays silent until it has seen its first 0. That places the pairing of short intervals at cell boundaries. A long interval that arrives while one short interval waits for its partner is a framing error. The block then drops its lock and locks again on the next 0. When no transition arrives for a programmable number of ticks, the block reports signal loss and goes back to waiting for a 0. Frame assembly and sync-word search are left to a downstream block.

Top module: `bmc_bit_decoder`

## Requirements
- R1: Inputs are only looked at in cycles where tick_i is 1. A sample is zero when zero_i=1; otherwise it is negative when sign_i=1 and positive when sign_i=0. A transition is a positive↔negative reversal, or a step from a nonzero sample to a zero sample. A step from zero to nonzero is not a transition. After reset the previous sample counts as zero.
- R2: The interval is the number of ticks from one transition tick to the next. Once the decoder is locked, or while it waits for its first 0, a long interval with no short pending emits bit_valid_o=1 with bit_o=0. That 0 locks the decoder.
- R3: While locked, two consecutive short intervals emit bit_valid_o=1 with bit_o=1.
- R4: Before the first 0 after reset, after a loss and after an error, short intervals produce no bit and no error.
- R5: A long interval while one short is pending pulses frame_err_o with no bit. It also clears the pending short and the lock, so the next long interval emits a 0 and locks again.
- R6: An interval of THRESH_TICKS or more ticks (default 33) is long. An interval of THRESH_TICKS-1 ticks is short.
- R7: When LOSS_TICKS ticks (default 200) pass without a transition, sig_lost_o pulses exactly once and the interval count saturates. The lock and any pending short are cleared. The first transition after that only starts a new measurement.
- R8: During and after reset, bit_valid_o, bit_o, frame_err_o and sig_lost_o are 0.
- R9: bit_valid_o and frame_err_o are never high in the same cycle. Neither is high together with sig_lost_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample strobe, one cycle per sample period |
| sign_i | input | 1 | Sample polarity, 1 = negative |
| zero_i | input | 1 | Sample is exactly zero (overrides sign_i) |
| bit_valid_o | output | 1 | One-cycle strobe for a decoded bit |
| bit_o | output | 1 | Decoded bit value, meaningful with bit_valid_o |
| frame_err_o | output | 1 | One-cycle pulse on an unpaired short interval |
| sig_lost_o | output | 1 | One-cycle pulse when the line goes quiet |

## Verification
On every cycle the checker confirms several properties. Each emitted 0 traces back to a long interval and each emitted 1 to a short one. An error pulse only follows a long interval. The tick counter never passes its saturation value. The three output pulses never overlap in the conflicting pairs. Only the directed scenarios can show the sequence-dependent behaviour: silence before the first 0, the exact threshold boundary, which sample steps count as transitions, resynchronisation after an error, and the single loss pulse followed by a measurement-only first edge. These scenarios check the decoded bit order against expected sequences.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b10
  } level_e;

  function automatic level_e to_level(logic sign, logic zero);
    if (zero) return LVL_ZERO;
    return sign ? LVL_NEG : LVL_POS;
  endfunction

  // sign reversal, or nonzero stepping to exact zero
  function automatic logic is_transition(level_e prev, level_e cur);
    return ((prev == LVL_POS) && (cur == LVL_NEG)) ||
           ((prev == LVL_NEG) && (cur == LVL_POS)) ||
           ((prev != LVL_ZERO) && (cur == LVL_ZERO));
  endfunction

endpackage

// File: rtl/bmc_edge_detect.sv
module bmc_edge_detect
  import bmc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sign_i,
  input  logic zero_i,
  output logic edge_o
);

  level_e prev_q;
  level_e cur;

  assign cur    = to_level(sign_i, zero_i);
  assign edge_o = tick_i && is_transition(prev_q, cur);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prev_q <= LVL_ZERO;
    else if (tick_i) prev_q <= cur;
  end

endmodule

// File: rtl/bmc_interval_timer.sv
module bmc_interval_timer #(
  parameter int THRESH_TICKS = 33,
  parameter int LOSS_TICKS   = 200,
  parameter int CNT_W        = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             edge_i,
  output logic             iv_valid_o,
  output logic             iv_long_o,
  output logic             loss_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] THR = CNT_W'(THRESH_TICKS);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LOSS_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nxt;
  logic             ref_q;  // a measurement is running
  logic             iv_valid_q, iv_long_q, loss_q;

  assign nxt = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      ref_q      <= 1'b0;
      iv_valid_q <= 1'b0;
      iv_long_q  <= 1'b0;
      loss_q     <= 1'b0;
    end else begin
      iv_valid_q <= 1'b0;
      loss_q     <= 1'b0;
      if (tick_i) begin
        if (edge_i) begin
          iv_valid_q <= ref_q;
          iv_long_q  <= (nxt >= THR);
          cnt_q      <= '0;
          ref_q      <= 1'b1;
        end else if (ref_q) begin
          if (nxt >= LIM) begin
            cnt_q  <= LIM;
            ref_q  <= 1'b0;
            loss_q <= 1'b1;
          end else begin
            cnt_q <= nxt;
          end
        end
      end
    end
  end

  assign iv_valid_o = iv_valid_q;
  assign iv_long_o  = iv_long_q;
  assign loss_o     = loss_q;
  assign cnt_o      = cnt_q;

endmodule

// File: rtl/bmc_bit_assembler.sv
module bmc_bit_assembler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic iv_valid_i,
  input  logic iv_long_i,
  input  logic loss_i,
  output logic bit_valid_o,
  output logic bit_o,
  output logic frame_err_o,
  output logic sig_lost_o
);

  logic synced_q, pend_q;
  logic bit_valid_q, bit_q, err_q, lost_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      synced_q    <= 1'b0;
      pend_q      <= 1'b0;
      bit_valid_q <= 1'b0;
      bit_q       <= 1'b0;
      err_q       <= 1'b0;
      lost_q      <= 1'b0;
    end else begin
      bit_valid_q <= 1'b0;
      err_q       <= 1'b0;
      lost_q      <= 1'b0;
      if (loss_i) begin
        synced_q <= 1'b0;
        pend_q   <= 1'b0;
        lost_q   <= 1'b1;
      end else if (iv_valid_i) begin
        if (iv_long_i) begin
          if (pend_q) begin
            err_q    <= 1'b1;
            pend_q   <= 1'b0;
            synced_q <= 1'b0;
          end else begin
            bit_valid_q <= 1'b1;
            bit_q       <= 1'b0;
            synced_q    <= 1'b1;
          end
        end else if (synced_q) begin
          if (pend_q) begin
            bit_valid_q <= 1'b1;
            bit_q       <= 1'b1;
            pend_q      <= 1'b0;
          end else begin
            pend_q <= 1'b1;
          end
        end
      end
    end
  end

  assign bit_valid_o = bit_valid_q;
  assign bit_o       = bit_q;
  assign frame_err_o = err_q;
  assign sig_lost_o  = lost_q;

endmodule

// File: rtl/bmc_bit_decoder.sv
module bmc_bit_decoder #(
  parameter int THRESH_TICKS = 33,
  parameter int LOSS_TICKS   = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sign_i,
  input  logic zero_i,
  output logic bit_valid_o,
  output logic bit_o,
  output logic frame_err_o,
  output logic sig_lost_o
);

  localparam int CNT_W = $clog2(LOSS_TICKS + 2);

  logic             edge_w;
  logic             iv_valid_w, iv_long_w, loss_w;
  logic [CNT_W-1:0] cnt_w;

  bmc_edge_detect u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .sign_i (sign_i),
    .zero_i (zero_i),
    .edge_o (edge_w)
  );

  bmc_interval_timer #(
    .THRESH_TICKS (THRESH_TICKS),
    .LOSS_TICKS   (LOSS_TICKS),
    .CNT_W        (CNT_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .edge_i     (edge_w),
    .iv_valid_o (iv_valid_w),
    .iv_long_o  (iv_long_w),
    .loss_o     (loss_w),
    .cnt_o      (cnt_w)
  );

  bmc_bit_assembler u_asm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .iv_valid_i  (iv_valid_w),
    .iv_long_i   (iv_long_w),
    .loss_i      (loss_w),
    .bit_valid_o (bit_valid_o),
    .bit_o       (bit_o),
    .frame_err_o (frame_err_o),
    .sig_lost_o  (sig_lost_o)
  );

endmodule

// File: rtl/bmc_decoder_checker.sv
module bmc_decoder_checker #(
  parameter int LOSS_TICKS = 200,
  parameter int CNT_W      = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             iv_valid,
  input logic             iv_long,
  input logic             loss,
  input logic [CNT_W-1:0] cnt,
  input logic             bit_valid,
  input logic             bit_val,
  input logic             frame_err,
  input logic             sig_lost
);

  localparam logic [CNT_W-1:0] LIM = CNT_W'(LOSS_TICKS);

  a_r2_zero_from_long: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid && !bit_val) |-> $past(iv_valid && iv_long));

  a_r3_one_from_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid && bit_val) |-> $past(iv_valid && !iv_long));

  a_r5_err_from_long: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err |-> $past(iv_valid && iv_long));

  a_r7_cnt_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= LIM);

  a_r7_loss_from_timer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_lost |-> $past(loss));

  a_r9_bit_err_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_valid && frame_err));

  a_r9_loss_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_lost |-> (!bit_valid && !frame_err));

endmodule

bind bmc_bit_decoder bmc_decoder_checker #(
  .LOSS_TICKS (LOSS_TICKS),
  .CNT_W      (CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .iv_valid  (iv_valid_w),
  .iv_long   (iv_long_w),
  .loss      (loss_w),
  .cnt       (cnt_w),
  .bit_valid (bit_valid_o),
  .bit_val   (bit_o),
  .frame_err (frame_err_o),
  .sig_lost  (sig_lost_o)
);

// File: tb/tb_bmc_bit_decoder.sv
module tb_bmc_bit_decoder;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic sign_i = 1'b0;
  logic zero_i = 1'b1;
  logic bit_valid_o, bit_o, frame_err_o, sig_lost_o;

  int total = 0;
  int bad = 0;
  int lvl = 0;          // 1 pos, -1 neg, 0 zero
  logic [63:0] cap;
  int cap_n = 0;
  int err_n = 0;
  int lost_n = 0;

  always #10 clk_i = ~clk_i;

  bmc_bit_decoder dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .sign_i      (sign_i),
    .zero_i      (zero_i),
    .bit_valid_o (bit_valid_o),
    .bit_o       (bit_o),
    .frame_err_o (frame_err_o),
    .sig_lost_o  (sig_lost_o)
  );

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (bit_valid_o) begin
        if (cap_n < 64) cap[cap_n] = bit_o;
        cap_n = cap_n + 1;
      end
      if (frame_err_o) err_n = err_n + 1;
      if (sig_lost_o) lost_n = lost_n + 1;
    end
  end

  task automatic check(string req, int act, int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_seq(string req, int n, logic [15:0] exp);
    logic [15:0] mask;
    mask = 16'((32'd1 << n) - 1);
    check({req, " bit count"}, cap_n, n);
    check({req, " bit pattern"}, int'(cap[15:0] & mask), int'(exp & mask));
  endtask

  task automatic apply_reset();
    rst_ni = 1'b0;
    tick_i = 1'b0;
    zero_i = 1'b1;
    sign_i = 1'b0;
    lvl = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cap = '0;
    cap_n = 0;
    err_n = 0;
    lost_n = 0;
  endtask

  // n ticks at level l; inputs scrambled between ticks (R1: ignored without tick)
  task automatic hold(int l, int n);
    lvl = l;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      zero_i = (l == 0);
      sign_i = (l < 0);
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
      sign_i = ~sign_i;
      zero_i = ~zero_i;
      @(negedge clk_i);
    end
  endtask

  task automatic send_iv(int n);
    hold((lvl > 0) ? -1 : 1, n);
  endtask

  task automatic flush();
    repeat (6) @(negedge clk_i);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R8 bit_valid in reset", bit_valid_o, 0);
    check("R8 frame_err in reset", frame_err_o, 0);
    apply_reset();
    hold(1, 5);
    flush();
    check("R8 bit_o after reset", bit_o, 0);
    check("R8 sig_lost after reset", sig_lost_o, 0);
  endtask

  // R4: shorts before first 0 silent; R2/R3 stream
  task automatic t_preamble();
    apply_reset();
    hold(1, 5);
    repeat (4) send_iv(23);
    send_iv(46);                      // 0
    send_iv(23); send_iv(23);         // 1
    send_iv(46);                      // 0
    send_iv(23); send_iv(23);         // 1
    send_iv(23); send_iv(23);         // 1
    send_iv(46);                      // 0
    send_iv(3);
    flush();
    check_seq("R4 R2 R3 preamble stream", 6, 16'h001A);
    check("R4 no error before sync", err_n, 0);
  endtask

  // R6: exactly threshold is long, one below is short
  task automatic t_threshold();
    apply_reset();
    hold(1, 5);
    send_iv(46);
    send_iv(33);
    send_iv(33);
    send_iv(32);
    send_iv(32);
    send_iv(3);
    flush();
    check_seq("R6 threshold", 4, 16'h0008);
    check("R6 no error", err_n, 0);
  endtask

  // R5: unpaired short then long
  task automatic t_frame_error();
    apply_reset();
    hold(1, 5);
    send_iv(46);                 // 0
    send_iv(23);                 // pending
    send_iv(46);                 // error
    send_iv(23); send_iv(23);    // unsynced, ignored
    send_iv(46);                 // 0, resync
    send_iv(23); send_iv(23);    // 1
    send_iv(3);
    flush();
    check_seq("R5 resync after error", 3, 16'h0004);
    check("R5 error count", err_n, 1);
  endtask

  // R1: pos->zero is an edge, zero->neg is not
  task automatic t_zero_steps();
    apply_reset();
    hold(1, 5);
    hold(-1, 46);
    hold(1, 46);
    hold(0, 20);
    hold(-1, 26);
    hold(1, 5);
    hold(-1, 3);
    flush();
    check_seq("R1 zero-step transitions", 3, 16'h0000);
    check("R1 no error", err_n, 0);
  endtask

  // R7: loss once, then first edge only starts timing
  task automatic t_loss();
    apply_reset();
    hold(1, 5);
    send_iv(46);
    send_iv(250);
    flush();
    check("R7 single loss pulse", lost_n, 1);
    send_iv(23);
    send_iv(23);
    send_iv(46);
    send_iv(3);
    flush();
    check_seq("R7 relock after loss", 2, 16'h0000);
    check("R7 loss not repeated", lost_n, 1);
    check("R7 no error", err_n, 0);
  endtask

  initial begin
    t_reset();
    t_preamble();
    t_threshold();
    t_frame_error();
    t_zero_steps();
    t_loss();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    total = total + 1;
    bad = bad + 1;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule